// File: doc/BRIEF.md
# Reconfigurable Convolutional Symbol Generator

This block feeds the branch-metric stage of a Viterbi decoder whose code can change at run time. After a start strobe it captures a constraint length, a code rate and a set of generator tap masks. It then steps through every trellis state of that code. For each state and each hypothesised input bit it presents the coded symbol an encoder would have emitted. Downstream logic compares received symbols with this stream, so no fixed code table is needed anywhere in the decoder.

Each step joins the hypothesised input bit, placed at register position K-1, with the (K-1)-bit state in positions K-2..0. Each output bit is the parity of that K-bit value masked by one tap mask. The consumer paces the stream with a ready input. A one-cycle completion pulse closes the walk.

Top module: `conv_symgen`

## Requirements
- R1: While reset is asserted, and after reset until a start is accepted, `valid_o`, `busy_o` and `done_o` are low whatever `ready_i` is. An asserted reset in the middle of a walk drops `busy_o` and `valid_o`.
- R2: When the block is idle, a high `start_i` at a clock edge captures `k_i`, `rate_i` and `poly_i`, and `busy_o` is high from that edge.
- R3: A walk delivers exactly 2^K tuples. States run in ascending order from 0 to 2^(K-1)-1, and each state gives input bit 0 first, then input bit 1.
- R4: Symbol bit i equals the XOR-reduction of ({input bit, state} AND tap mask i). The input bit is at position K-1. Tap mask i is `poly_i[i*9 +: 9]` for the default K_MAX of 9.
- R5: Tap-mask bits at positions K and above have no effect on any symbol.
- R6: Rate code 0 gives 2 symbol bits, code 1 gives 3, and codes 2 and 3 give 4. Symbol bits at or above that count read zero.
- R7: A constraint length below 3 is treated as 3. One above 9 is treated as 9.
- R8: `valid_o` is high exactly when the block is busy and `ready_i` is high. A tuple is handed over in that cycle and then the next tuple follows. While `ready_i` is low, the presented state and bit stay unchanged.
- R9: `done_o` is high for exactly one cycle, the cycle after the last tuple is handed over. `busy_o` is low in that cycle.
- R10: `start_i` and changes on the configuration inputs while busy have no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| k_i | input | 4 | Constraint length K |
| rate_i | input | 2 | Rate code: 0 = 1/2, 1 = 1/3, 2 or 3 = 1/4 |
| poly_i | input | 36 | Four 9-bit tap masks, mask i in bits i*9+8..i*9 |
| ready_i | input | 1 | Consumer can take a tuple this cycle |
| valid_o | output | 1 | Tuple handed over this cycle |
| state_o | output | 8 | Trellis state of the presented tuple |
| bit_o | output | 1 | Hypothesised input bit of the presented tuple |
| sym_o | output | 4 | Expected coded symbol |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse after the final tuple |

## Verification
The tuple outputs and `valid_o` are combinational from registered position and configuration, plus the live `ready_i`. A tuple can therefore be checked within the same cycle in which ready is driven. The bench drives inputs just after the falling edge and samples one time step later, before the next rising edge. `busy_o` is due one rising edge after the accepted start. `done_o` is due one rising edge after the final handshake and must be gone one edge later. The bench samples at the falling edge that follows each of those edges.

// File: rtl/symgen_pkg.sv
package symgen_pkg;

    typedef enum logic [1:0] {
        RATE_HALF    = 2'd0,
        RATE_THIRD   = 2'd1,
        RATE_QUARTER = 2'd2,
        RATE_SPARE   = 2'd3
    } rate_code_e;

    // Number of symbol bits produced for a rate code.
    function automatic logic [2:0] rate_width(input logic [1:0] code);
        logic [2:0] w;
        case (rate_code_e'(code))
            RATE_HALF:  w = 3'd2;
            RATE_THIRD: w = 3'd3;
            default:    w = 3'd4;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/symgen_cfg.sv
module symgen_cfg
    import symgen_pkg::*;
#(
    parameter int K_MIN = 3,
    parameter int K_MAX = 9,
    parameter int N_MAX = 4,
    localparam int KW = $clog2(K_MAX + 1),
    localparam int PW = N_MAX * K_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [KW-1:0] k_i,
    input  logic [1:0]    rate_i,
    input  logic [PW-1:0] poly_i,
    output logic [KW-1:0] k_o,
    output logic [2:0]    nout_o,
    output logic [PW-1:0] poly_o
);

    typedef struct packed {
        logic [KW-1:0] k;
        logic [2:0]    nout;
        logic [PW-1:0] poly;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [KW-1:0]    k_sel;
    logic [K_MAX-1:0] tap_keep;
    logic [K_MAX-1:0] held_keep;

    always_comb begin
        k_sel = k_i;
        if (k_i < KW'(K_MIN)) begin
            k_sel = KW'(K_MIN);
        end else if (k_i > KW'(K_MAX)) begin
            k_sel = KW'(K_MAX);
        end
        tap_keep = ~({K_MAX{1'b1}} << k_sel);

        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.k    = k_sel;
            cfg_d.nout = rate_width(rate_i);
            for (int i = 0; i < N_MAX; i++) begin
                cfg_d.poly[i*K_MAX +: K_MAX] = poly_i[i*K_MAX +: K_MAX] & tap_keep;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{k: KW'(K_MIN), nout: 3'd2, poly: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign k_o       = cfg_q.k;
    assign nout_o    = cfg_q.nout;
    assign poly_o    = cfg_q.poly;
    assign held_keep = ~({K_MAX{1'b1}} << cfg_q.k);

    // R7: the stored constraint length never leaves the supported window
    a_r7_k_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.k >= KW'(K_MIN)) && (cfg_q.k <= KW'(K_MAX)));

    // R10: configuration only moves on an accepted start
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q));

    for (genvar g = 0; g < N_MAX; g++) begin : g_tapchk
        // R5: no stored tap survives at or above position K
        a_r5_taps_trimmed: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.poly[g*K_MAX +: K_MAX] & ~held_keep) == '0);
    end

endmodule

// File: rtl/symgen_seq.sv
module symgen_seq #(
    parameter int K_MAX = 9,
    localparam int KW = $clog2(K_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ready_i,
    input  logic [KW-1:0]    k_i,
    output logic             load_o,
    output logic             valid_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [K_MAX-1:0] pos_o
);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [K_MAX-1:0] pos;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [K_MAX-1:0] final_pos;
    logic             at_last;
    logic             take;
    logic             load;

    always_comb begin
        final_pos = ~({K_MAX{1'b1}} << k_i);
        at_last   = (seq_q.pos == final_pos);
        load      = start_i & ~seq_q.run;
        take      = seq_q.run & ready_i;

        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (load) begin
            seq_d.run = 1'b1;
            seq_d.pos = '0;
        end else if (take) begin
            if (at_last) begin
                seq_d.run  = 1'b0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.pos = seq_q.pos + K_MAX'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{run: 1'b0, done: 1'b0, pos: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign load_o  = load;
    assign valid_o = take;
    assign busy_o  = seq_q.run;
    assign done_o  = seq_q.done;
    assign pos_o   = seq_q.pos;

    // R3: a handed-over tuple that is not the last advances the position by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !at_last) |=> (seq_q.run && seq_q.pos == $past(seq_q.pos) + K_MAX'(1)));

    // R8: a stall keeps the walk and its position
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && !ready_i) |=> (seq_q.run && $stable(seq_q.pos)));

    // R9: final handshake is followed by completion and idle
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && at_last) |=> (seq_q.done && !seq_q.run));

    // R9: completion lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // R10: a start during a walk does not restart it
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && start_i && !ready_i) |=> (seq_q.run && $stable(seq_q.pos)));

endmodule

// File: rtl/symgen_enc.sv
module symgen_enc #(
    parameter int K_MAX = 9,
    parameter int N_MAX = 4,
    localparam int KW = $clog2(K_MAX + 1),
    localparam int PW = N_MAX * K_MAX
) (
    input  logic [KW-1:0]    k_i,
    input  logic [2:0]       nout_i,
    input  logic [PW-1:0]    poly_i,
    input  logic [K_MAX-2:0] state_i,
    input  logic             bit_i,
    output logic [N_MAX-1:0] sym_o
);

    logic [K_MAX-1:0] shreg;
    logic [N_MAX-1:0] parity;

    always_comb begin
        shreg = K_MAX'(state_i) | (K_MAX'(bit_i) << (k_i - KW'(1)));
    end

    for (genvar g = 0; g < N_MAX; g++) begin : g_tap
        assign parity[g] = ^(shreg & poly_i[g*K_MAX +: K_MAX]);
    end

    always_comb begin
        for (int i = 0; i < N_MAX; i++) begin
            sym_o[i] = (i < int'(nout_i)) ? parity[i] : 1'b0;
        end
        // R6: nothing above the active symbol width is driven
        a_r6_unused_zero: assert ((int'(nout_i) >= N_MAX) || ((sym_o >> nout_i) == '0));
    end

endmodule

// File: rtl/conv_symgen.sv
module conv_symgen #(
    parameter int K_MIN = 3,
    parameter int K_MAX = 9,
    parameter int N_MAX = 4,
    localparam int KW = $clog2(K_MAX + 1),
    localparam int PW = N_MAX * K_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KW-1:0]    k_i,
    input  logic [1:0]       rate_i,
    input  logic [PW-1:0]    poly_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [K_MAX-2:0] state_o,
    output logic             bit_o,
    output logic [N_MAX-1:0] sym_o,
    output logic             busy_o,
    output logic             done_o
);

    logic             load;
    logic [KW-1:0]    k_q;
    logic [2:0]       nout_q;
    logic [PW-1:0]    poly_q;
    logic [K_MAX-1:0] pos;

    symgen_cfg #(.K_MIN(K_MIN), .K_MAX(K_MAX), .N_MAX(N_MAX)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .k_i    (k_i),
        .rate_i (rate_i),
        .poly_i (poly_i),
        .k_o    (k_q),
        .nout_o (nout_q),
        .poly_o (poly_q)
    );

    symgen_seq #(.K_MAX(K_MAX)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ready_i (ready_i),
        .k_i     (k_q),
        .load_o  (load),
        .valid_o (valid_o),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .pos_o   (pos)
    );

    assign state_o = pos[K_MAX-1:1];
    assign bit_o   = pos[0];

    symgen_enc #(.K_MAX(K_MAX), .N_MAX(N_MAX)) u_enc (
        .k_i     (k_q),
        .nout_i  (nout_q),
        .poly_i  (poly_q),
        .state_i (state_o),
        .bit_i   (bit_o),
        .sym_o   (sym_o)
    );

    // R1: no tuple is offered outside a walk
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !valid_o);

    // R2: an idle start makes the block busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

endmodule

// File: tb/test_conv_symgen.sv
module test_conv_symgen;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int KW = 4;
    localparam int PW = 36;
    localparam int NV = 12;

    // {k[3:0], rate[1:0], taps[35:0]}
    localparam logic [41:0] VEC [NV] = '{
        {4'd3,  2'd0, 36'hF3A5C9E17},
        {4'd4,  2'd1, 36'h9B1D2E4F6},
        {4'd5,  2'd2, 36'hA5A5A5A5A},
        {4'd6,  2'd0, 36'h123456789},
        {4'd7,  2'd1, 36'hFEDCBA987},
        {4'd8,  2'd2, 36'h0F1E2D3C4},
        {4'd9,  2'd0, 36'h1ED16D0F5},
        {4'd9,  2'd1, 36'h5B6D3CE71},
        {4'd9,  2'd2, 36'h3A9F27C4B},
        {4'd2,  2'd1, 36'hC8E1A3957},
        {4'd15, 2'd2, 36'h7D3B19E62},
        {4'd5,  2'd3, 36'hE29F6B0C3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [KW-1:0] k_i = 4'd3;
    logic [1:0]    rate_i = 2'd0;
    logic [PW-1:0] poly_i = '0;
    logic          ready_i = 1'b0;
    logic          valid_o;
    logic [7:0]    state_o;
    logic          bit_o;
    logic [3:0]    sym_o;
    logic          busy_o;
    logic          done_o;

    int            n_run = 0;
    int            n_fail = 0;
    logic [7:0]    lfsr = 8'hA7;

    conv_symgen i_conv_symgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .k_i     (k_i),
        .rate_i  (rate_i),
        .poly_i  (poly_i),
        .ready_i (ready_i),
        .valid_o (valid_o),
        .state_o (state_o),
        .bit_o   (bit_o),
        .sym_o   (sym_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_k(input int k);
        if (k < 3) return 3;
        if (k > 9) return 9;
        return k;
    endfunction

    function automatic int width_of(input int r);
        if (r == 0) return 2;
        if (r == 1) return 3;
        return 4;
    endfunction

    // Bit-serial reference convolution.
    function automatic int model(input int k, input int r, input logic [PW-1:0] p,
                                 input int st, input int b);
        int kk = clamp_k(k);
        int regv = st + (b << (kk - 1));
        int res = 0;
        for (int i = 0; i < width_of(r); i++) begin
            int acc = 0;
            for (int j = 0; j < kk; j++) begin
                acc = acc ^ (((regv >> j) & 1) & int'(p[i*9 + j]));
            end
            res = res | (acc << i);
        end
        return res;
    endfunction

    task automatic run_case(input int k, input int r, input logic [PW-1:0] p,
                            input bit stall, input bit disturb, input string tag);
        int kk = clamp_k(k);
        int n = 1 << kk;
        int cnt = 0;
        int guard = 0;
        int expw;
        @(negedge clk);
        k_i = KW'(k); rate_i = 2'(r); poly_i = p; start_i = 1'b1; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        #1 check("R2", "busy after start", int'(busy_o), 1);
        while (cnt < n && guard < 4*n + 64) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ready_i = stall ? (lfsr[0] | lfsr[1]) : 1'b1;
            if (disturb) begin
                poly_i  = ~poly_i;
                k_i     = k_i ^ 4'h6;
                rate_i  = rate_i + 2'd1;
                start_i = (guard % 5 == 2);
            end
            #1;
            if (ready_i) begin
                check("R8", "valid with ready", int'(valid_o), 1);
                expw = ((cnt >> 1) << 5) | ((cnt & 1) << 4) | model(k, r, p, cnt >> 1, cnt & 1);
                check(tag, "state/bit/symbol", int'({state_o, bit_o, sym_o}), expw);
                cnt++;
            end else begin
                check("R8", "valid low on stall", int'(valid_o), 0);
                check("R8", "position held on stall", int'({state_o, bit_o}), cnt);
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        #1;
        check("R3", "tuple count", cnt, n);
        check("R9", "done pulse", int'(done_o), 1);
        check("R9", "busy cleared with done", int'(busy_o), 0);
        @(negedge clk);
        #1 check("R9", "done lasts one cycle", int'(done_o), 0);
    endtask

    initial begin
        #3000000;
        n_run++;
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        ready_i = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "valid in reset", int'(valid_o), 0);
        check("R1", "busy in reset", int'(busy_o), 0);
        check("R1", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R1", "no valid before start", int'(valid_o), 0);
        check("R1", "idle before start", int'(busy_o), 0);
        ready_i = 1'b0;

        for (int v = 0; v < NV; v++) begin
            string tag;
            if (v == 9 || v == 10) tag = "R7 R4";
            else if (v == 11) tag = "R6 R4";
            else if (v == 7) tag = "R10 R4";
            else tag = "R4 R5 R3";
            run_case(int'(VEC[v][41:38]), int'(VEC[v][37:36]), VEC[v][35:0],
                     (v % 2) == 1, v == 7, tag);
        end

        // Directed: reset in the middle of a walk.
        @(negedge clk);
        k_i = 4'd6; rate_i = 2'd1; poly_i = 36'h5A5A5A5A5; start_i = 1'b1; ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (7) @(negedge clk);
        #1 check("R2", "busy mid walk", int'(busy_o), 1);
        rst_n = 1'b0;
        #1;
        check("R1", "busy dropped by reset", int'(busy_o), 0);
        check("R1", "valid dropped by reset", int'(valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R1", "idle after mid-walk reset", int'(valid_o), 0);
        ready_i = 1'b0;

        // Directed: all-ones taps beyond K at K=3, rate 1/4.
        run_case(3, 2, 36'hFFFFFFFFF, 1'b0, 1'b0, "R5 R6");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule